// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by reading a two-level page table out of main memory. Pages are 4 KB: the low 12 bits of the virtual address pass through unchanged as the page offset. The upper 20 bits form the virtual page number, which splits into two 10-bit indices. The upper index selects an entry in the top-level directory. The lower index selects an entry in the second-level table that the directory entry points to. Each table holds 1024 entries of 32 bits, so each one fills exactly one 4 KB frame.

A base register holds the start address of the running process's directory. A context-switch strobe reloads it. Each translation request carries an access kind: read, write or execute. The walker issues two word reads one after the other through a simple memory port that has variable latency. It answers with the physical address, with a page-fault flag, or with a protection-violation flag. When a permitted write lands on a page whose dirty bit is clear, the walker first writes the second-level entry back with that bit set, and only then responds.

Top module: `pt_walker`

## Requirements
- R1: On success, rsp_paddr equals the frame field [31:12] of the second-level entry joined with req_vaddr[11:0], and both fault flags are low.
- R2: The first read goes to ctx base + 4 * req_vaddr[31:22]. The second read goes to (directory entry[31:12] << 12) + 4 * req_vaddr[21:12].
- R3: The second read is issued only after the directory data has returned. While mem_req is high and mem_rvalid is low, mem_addr, mem_we and mem_wdata hold steady.
- R4: If present bit [11] is clear in the directory entry, the walk ends after one read with rsp_fault. If it is clear in the second-level entry, the walk ends with rsp_fault. Fault takes priority over protection, and a failed walk returns rsp_paddr = 0.
- R5: The access code is 0 = read, 1 = write, 2 = execute, and 3 is treated as read. Each kind needs its bit in the second-level entry: bit 10 for read, bit 9 for write, bit 8 for execute. A missing permission gives rsp_prot with rsp_paddr = 0. Permission bits in the directory entry are ignored.
- R6: A permitted write to an entry whose dirty bit [7] is clear causes exactly one memory write, before rsp_valid. The write goes to the second-level entry's address, and its data is that entry with bit 7 set. Reads, and writes to entries already dirty, cause no memory write.
- R7: A ctx_load pulse loads ctx_base into the base register. A request accepted in the same cycle already uses the new value. A pulse during a walk does not change that walk's addresses but applies to later requests.
- R8: req_ready is high only while no walk is in progress. Each accepted request produces exactly one rsp_valid pulse, one cycle long.
- R9: After reset, req_ready is 1, and rsp_valid and mem_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_load | input | 1 | Context-switch strobe, loads the base register |
| ctx_base | input | 32 | New directory base address (4 KB aligned) |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted when both are high |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_fault | output | 1 | Page not present |
| rsp_prot | output | 1 | Access not permitted |
| mem_req | output | 1 | Memory access request, held until mem_rvalid |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Access complete (read data valid or write done) |
| mem_rdata | input | 32 | Read data |

## Verification
The two functions that can fall in the same cycle are the context-switch reload of the base register and the acceptance of a new request. The bench raises ctx_load and req_valid on the same edge with a different base. It judges the result by the first read address and the final physical address, which must both come from the new directory. It also pulses ctx_load in the middle of a slow walk. That walk must keep the old base, and the following request must use the new one. Random traffic with random memory latency checks every read address, every write-back and every response against a reference walk computed in the bench.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ADDR_W   = 32;
  localparam int OFF_W    = 12;
  localparam int IDX_W    = 10;
  localparam int FRAME_W  = ADDR_W - OFF_W;
  localparam int WORD_LG  = 2;
  localparam int ENT_W    = 32;

  localparam int B_PRES  = 11;
  localparam int B_RD    = 10;
  localparam int B_WR    = 9;
  localparam int B_EX    = 8;
  localparam int B_DIRTY = 7;

  typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_EXEC = 2'd2, ACC_RSVD = 2'd3} acc_e;
  typedef enum logic [1:0] {ST_IDLE, ST_DIR, ST_LEAF, ST_MARK} walk_st_e;

  typedef struct packed {
    logic present;
    logic perm_ok;
    logic mark_dirty;
  } ent_chk_t;
endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_val,
  output logic [ADDR_W-1:0] base_eff
);
  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst)     base_q <= '0;
    else if (ld) base_q <= ld_val;
  end

  // forward a same-cycle reload to the request being accepted (R7)
  assign base_eff = ld ? ld_val : base_q;
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
  import ptw_pkg::*;
(
  input  logic [ENT_W-1:0] entry,
  input  acc_e             acc,
  output ent_chk_t         chk,
  output logic [ENT_W-1:0] marked
);
  logic allow;

  always_comb begin
    unique case (acc)
      ACC_WRITE: allow = entry[B_WR];
      ACC_EXEC:  allow = entry[B_EX];
      default:   allow = entry[B_RD];
    endcase
  end

  assign chk.present    = entry[B_PRES];
  assign chk.perm_ok    = allow;
  assign chk.mark_dirty = (acc == ACC_WRITE) && !entry[B_DIRTY];
  assign marked         = entry | (ENT_W'(1) << B_DIRTY);
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base_eff,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  acc_e              req_acc,
  output acc_e              acc_q,
  input  ent_chk_t          chk,
  input  logic [ENT_W-1:0]  marked,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic              rsp_prot,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ENT_W-1:0]  mem_wdata,
  input  logic              mem_rvalid,
  input  logic [ENT_W-1:0]  mem_rdata
);
  localparam int LOW_W = IDX_W + OFF_W;

  walk_st_e           st;
  logic [LOW_W-1:0]   va_q;
  logic [FRAME_W-1:0] frame_q;

  assign req_ready = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      va_q      <= '0;
      acc_q     <= ACC_READ;
      frame_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      rsp_prot  <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            va_q     <= req_vaddr[LOW_W-1:0];
            acc_q    <= req_acc;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= base_eff + {20'd0, req_vaddr[ADDR_W-1:LOW_W], 2'b00};
            st       <= ST_DIR;
          end
        end
        ST_DIR: begin
          if (mem_rvalid) begin
            if (!chk.present) begin
              mem_req   <= 1'b0;
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b1;
              rsp_prot  <= 1'b0;
              rsp_paddr <= '0;
              st        <= ST_IDLE;
            end else begin
              mem_addr <= {mem_rdata[ENT_W-1:OFF_W], va_q[LOW_W-1:OFF_W], 2'b00};
              st       <= ST_LEAF;
            end
          end
        end
        ST_LEAF: begin
          if (mem_rvalid) begin
            if (!chk.present || !chk.perm_ok) begin
              mem_req   <= 1'b0;
              rsp_valid <= 1'b1;
              rsp_fault <= !chk.present;
              rsp_prot  <= chk.present;
              rsp_paddr <= '0;
              st        <= ST_IDLE;
            end else if (chk.mark_dirty) begin
              mem_we    <= 1'b1;
              mem_wdata <= marked;
              frame_q   <= mem_rdata[ENT_W-1:OFF_W];
              st        <= ST_MARK;
            end else begin
              mem_req   <= 1'b0;
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b0;
              rsp_prot  <= 1'b0;
              rsp_paddr <= {mem_rdata[ENT_W-1:OFF_W], va_q[OFF_W-1:0]};
              st        <= ST_IDLE;
            end
          end
        end
        ST_MARK: begin
          if (mem_rvalid) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b0;
            rsp_prot  <= 1'b0;
            rsp_paddr <= {frame_q, va_q[OFF_W-1:0]};
            st        <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: an outstanding access keeps its address and kind until completion
  a_r3_hold_access: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R8: response is a single-cycle pulse and never coincides with a busy walker
  a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  a_r8_no_rsp_busy: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !mem_req);

  // R4: the two failure flags never appear together
  a_r4_flags_excl: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !(rsp_fault && rsp_prot));

  // R4/R5: failed walks return no address
  a_r5_fail_no_addr: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_fault || rsp_prot)) |-> (rsp_paddr == '0));

  // R6: a write access only follows a permitted leaf read
  a_r6_write_after_leaf: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> ($past(mem_rvalid) && mem_req));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ctx_load,
  input  logic [31:0] ctx_base,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic [1:0]  req_acc,
  output logic        rsp_valid,
  output logic [31:0] rsp_paddr,
  output logic        rsp_fault,
  output logic        rsp_prot,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  logic [ADDR_W-1:0] base_eff;
  acc_e              acc_q;
  ent_chk_t          chk;
  logic [ENT_W-1:0]  marked;

  ptw_base_reg u_base (
    .clk      (clk),
    .rst      (rst),
    .ld       (ctx_load),
    .ld_val   (ctx_base),
    .base_eff (base_eff)
  );

  ptw_entry_check u_chk (
    .entry  (mem_rdata),
    .acc    (acc_q),
    .chk    (chk),
    .marked (marked)
  );

  ptw_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .base_eff   (base_eff),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_vaddr  (req_vaddr),
    .req_acc    (acc_e'(req_acc)),
    .acc_q      (acc_q),
    .chk        (chk),
    .marked     (marked),
    .rsp_valid  (rsp_valid),
    .rsp_paddr  (rsp_paddr),
    .rsp_fault  (rsp_fault),
    .rsp_prot   (rsp_prot),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata)
  );
endmodule

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctx_load = 1'b0;
  logic [31:0] ctx_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid, rsp_fault, rsp_prot;
  logic [31:0] rsp_paddr;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  pt_walker u_dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // memory model
  logic [31:0] mem [logic [31:0]];
  int          lat = 0;
  bit          pend = 0;
  int          cnt = 0;
  logic [31:0] rd_log [4];
  int          rd_cnt = 0, wr_cnt = 0;
  logic [31:0] wr_addr, wr_data;

  function automatic logic [31:0] rdm(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'd0;
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      mem_rvalid = 0; pend = 0;
    end else begin
      if (mem_rvalid) mem_rvalid = 0;
      else begin
        if (!pend && mem_req) begin pend = 1; cnt = lat; end
        if (pend) begin
          if (cnt == 0) begin
            pend = 0; mem_rvalid = 1;
            if (mem_we) begin
              mem[mem_addr] = mem_wdata; wr_cnt++; wr_addr = mem_addr; wr_data = mem_wdata;
            end else begin
              mem_rdata = rdm(mem_addr);
              if (rd_cnt < 4) rd_log[rd_cnt] = mem_addr;
              rd_cnt++;
            end
          end else cnt--;
        end
      end
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference walk
  task automatic ref_walk(input logic [31:0] base, input logic [31:0] va, input logic [1:0] acc,
                          output bit f, output bit p, output logic [31:0] pa, output int nrd,
                          output logic [31:0] a0, output logic [31:0] a1,
                          output bit wr, output logic [31:0] wd);
    logic [31:0] pde, pte;
    bit ok;
    f = 0; p = 0; pa = 0; wr = 0; wd = 0; a1 = 0;
    a0 = base + {20'd0, va[31:22], 2'b00};
    pde = rdm(a0); nrd = 1;
    if (!pde[11]) begin f = 1; return; end
    a1 = {pde[31:12], va[21:12], 2'b00};
    pte = rdm(a1); nrd = 2;
    if (!pte[11]) begin f = 1; return; end
    ok = (acc == 2'd1) ? pte[9] : (acc == 2'd2) ? pte[8] : pte[10];
    if (!ok) begin p = 1; return; end
    pa = {pte[31:12], va[11:0]};
    if (acc == 2'd1 && !pte[7]) begin wr = 1; wd = pte | 32'h80; end
  endtask

  logic [31:0] cur_base;

  // mid_ld: pulse ctx_load with mid_base during the walk
  task automatic txn(logic [31:0] va, logic [1:0] acc, bit same_ld, logic [31:0] new_base,
                     bit mid_ld, logic [31:0] mid_base, string tag);
    bit f, p, wr; logic [31:0] pa, a0, a1, wd; int nrd, t;
    if (same_ld) cur_base = new_base;
    ref_walk(cur_base, va, acc, f, p, pa, nrd, a0, a1, wr, wd);
    rd_cnt = 0; wr_cnt = 0;
    check(req_ready == 1'b1, {"R8 ready idle ", tag}, req_ready, 1);
    req_valid = 1; req_vaddr = va; req_acc = acc;
    if (same_ld) begin ctx_load = 1; ctx_base = new_base; end
    @(negedge clk);
    req_valid = 0; ctx_load = 0;
    check(req_ready == 1'b0 || rsp_valid, {"R8 busy ", tag}, req_ready, 0);
    if (mid_ld) begin ctx_load = 1; ctx_base = mid_base; cur_base = mid_base; end
    t = 0;
    while (!rsp_valid && t < 200) begin
      @(negedge clk); ctx_load = 0; t++;
    end
    ctx_load = 0;
    check(rsp_valid, {"R8 response ", tag}, rsp_valid, 1);
    check(rsp_fault == f, {"R4 fault ", tag}, rsp_fault, f);
    check(rsp_prot == p, {"R5 prot ", tag}, rsp_prot, p);
    check(rsp_paddr == pa, {"R1 paddr ", tag}, rsp_paddr, pa);
    check(rd_cnt == nrd, {"R3 read count ", tag}, rd_cnt, nrd);
    check(rd_log[0] == a0, {"R2 dir addr ", tag}, rd_log[0], a0);
    if (nrd == 2) check(rd_log[1] == a1, {"R2 leaf addr ", tag}, rd_log[1], a1);
    check(wr_cnt == int'(wr), {"R6 write count ", tag}, wr_cnt, wr);
    if (wr) begin
      check(wr_addr == a1, {"R6 write addr ", tag}, wr_addr, a1);
      check(wr_data == wd, {"R6 write data ", tag}, wr_data, wd);
    end
    @(negedge clk);
    check(!rsp_valid, {"R8 pulse ", tag}, rsp_valid, 0);
  endtask

  localparam logic [31:0] BASE_A = 32'h0010_0000;
  localparam logic [31:0] BASE_B = 32'h0030_0000;

  function automatic logic [31:0] mkent(logic [19:0] fr, bit pr, bit r, bit w, bit x, bit d);
    return {fr, pr, r, w, x, d, 7'd0};
  endfunction

  task automatic ensure_leaf(logic [31:0] base, logic [31:0] va);
    logic [31:0] pde, a;
    pde = rdm(base + {20'd0, va[31:22], 2'b00});
    a = {pde[31:12], va[21:12], 2'b00};
    if (pde[11] && !mem.exists(a))
      mem[a] = mkent(20'($urandom), ($urandom % 8) != 0, $urandom % 2, $urandom % 2,
                     $urandom % 2, $urandom % 2);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] va; logic [1:0] acc;
    void'($urandom(457));
    // directories: A uses idx 0..7 (7 absent), B uses idx 0..7 with other tables
    for (int i = 0; i < 8; i++) begin
      mem[BASE_A + 4*i] = mkent(20'h00200 + 20'(i), i != 7, 0, 0, 0, 0);
      mem[BASE_B + 4*i] = mkent(20'h00400 + 20'(i), 1, 0, 0, 0, 0);
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    check(req_ready == 1, "R9 ready", req_ready, 1);
    check(rsp_valid == 0, "R9 rsp_valid", rsp_valid, 0);
    check(mem_req == 0, "R9 mem_req", mem_req, 0);
    cur_base = 32'd0;

    // R7: load and request in the same cycle
    mem[32'h0020_0000 + 4*5] = mkent(20'hABCDE, 1, 1, 1, 1, 1);
    mem[32'h0040_0000 + 4*5] = mkent(20'h12345, 1, 1, 1, 1, 1);
    txn(32'h0000_5123, 2'd0, 1, BASE_A, 0, 0, "R7 same-cycle load A");
    txn(32'h0000_5FFF, 2'd0, 1, BASE_B, 0, 0, "R7 same-cycle load B");
    txn(32'h0000_5000, 2'd2, 0, 0, 0, 0, "R7 base kept B");
    // R7: load during a slow walk
    lat = 3;
    txn(32'h0000_5010, 2'd0, 0, 0, 1, BASE_A, "R7 mid-walk load");
    txn(32'h0000_5020, 2'd0, 0, 0, 0, 0, "R7 after mid-walk load");
    lat = 0;
    // R4 directory absent, leaf absent
    txn(32'h01C0_0000, 2'd0, 0, 0, 0, 0, "R4 dir absent");
    mem[32'h0020_0000 + 4*9] = mkent(20'h11111, 0, 1, 1, 1, 0);
    txn(32'h0000_9004, 2'd3, 0, 0, 0, 0, "R4 leaf absent priority");
    // R5 each permission missing; directory bits ignored
    mem[32'h0020_0000 + 4*10] = mkent(20'h22222, 1, 0, 1, 1, 0);
    mem[32'h0020_0000 + 4*11] = mkent(20'h33333, 1, 1, 0, 1, 0);
    mem[32'h0020_0000 + 4*12] = mkent(20'h44444, 1, 1, 1, 0, 0);
    txn(32'h0000_A000, 2'd0, 0, 0, 0, 0, "R5 no read");
    txn(32'h0000_A000, 2'd3, 0, 0, 0, 0, "R5 code3 as read");
    txn(32'h0000_B000, 2'd1, 0, 0, 0, 0, "R5 no write");
    txn(32'h0000_C000, 2'd2, 0, 0, 0, 0, "R5 no exec");
    // R6 dirty marking then no second write
    lat = 2;
    txn(32'h0000_C7FF, 2'd1, 0, 0, 0, 0, "R6 first write marks");
    txn(32'h0000_C001, 2'd1, 0, 0, 0, 0, "R6 already dirty");
    txn(32'h0000_C002, 2'd0, 0, 0, 0, 0, "R6 read no write");
    // random traffic
    for (int n = 0; n < 300; n++) begin
      va = {7'd0, 3'($urandom), 10'($urandom % 16), 12'($urandom)};
      acc = 2'($urandom);
      lat = $urandom % 4;
      ensure_leaf(cur_base, va);
      txn(va, acc, 0, 0, 0, 0, "R1 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule